// File: doc/BRIEF.md
# Ten-State Twisted-Ring Counter with One-Hot Decode

This block counts events presented on two slow, asynchronous control inputs and shows the count as ten one-hot select lines plus a carry line. Inside it, a five-bit twisted-ring (Johnson) register steps through ten patterns. Only one bit of the register changes per step. Each select line is formed from just two neighbouring register bits, so a step can never produce a brief false select.

The count input, the active-low count gate and the count clear all arrive from outside the system clock domain. Each passes through a two-flop synchronizer. A step is taken for either of two qualifying events: the count input rises while the gate is low, or the gate falls while the count input is high. The clear input returns the count to zero and wins over everything else. The carry line is high for the first half of the ring and low for the second half. It therefore makes one rising edge per ten counts, which lets a following divider be clocked from it.

Top module: `jring_decade`

## Requirements
- R1: While the system reset `rst` is high, the count is forced to 0: `sel_o` = 10'b00_0000_0001 (bit k is count k) and `carry_o` = 1.
- R2: In every legal state exactly one bit of `sel_o` is high, and it is bit k for count k.
- R3: A rising edge of `cnt_in` while `gate_n_in` is low advances the count by one. The new value appears on the outputs after the third rising system clock edge that samples the changed input, and not after the second.
- R4: A falling edge of `gate_n_in` while `cnt_in` is high advances the count by one.
- R5: These events leave the count unchanged: a falling edge of `cnt_in`, a rising edge of `gate_n_in`, a rising edge of `cnt_in` while the gate is high, and a falling edge of the gate while `cnt_in` is low.
- R6: While the synchronized `clr_in` is high, the count is 0 and any qualifying count events are ignored.
- R7: The ring has ten states. The step after count 9 gives count 0.
- R8: `carry_o` is 1 for counts 0 to 4 and 0 for counts 5 to 9.
- R9: If the register holds any of the 22 unused patterns, the next qualifying event loads count 0.
- R10: A rising `cnt_in` and a falling `gate_n_in` seen in the same system cycle advance the count by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| cnt_in | input | 1 | Asynchronous count input |
| gate_n_in | input | 1 | Asynchronous active-low count gate; its falling edge also counts |
| clr_in | input | 1 | Asynchronous active-high count clear |
| sel_o | output | 10 | One-hot decoded count |
| carry_o | output | 1 | High for counts 0 to 4 |

## Verification
A wrong ring pattern shows up on the decode lines as soon as it exists. It appears as two lines high, no line high, or a select that skips or repeats, and the carry line moves out of step with the lower five selects in the same cycle. A wrong edge qualifier appears three system clocks after the offending input change: a count is gained or lost, and every later expected select differs from what the scoreboard holds. A forced unused pattern must fall back to count 0 on the very next qualifying event.

// File: rtl/jring_pkg.sv
package jring_pkg;

    localparam int STAGES     = 5;
    localparam int COUNTS     = 2 * STAGES;
    localparam int SYNC_DEPTH = 2;

    typedef logic [STAGES-1:0] ring_t;

    typedef struct packed {
        logic cnt;
        logic gate_n;
        logic clr;
    } ctl_t;

    // A ring pattern is legal when it has at most one boundary between
    // neighbouring bits (a run of ones against a run of zeros).
    function automatic logic ring_legal(input ring_t r);
        int edges;
        edges = 0;
        for (int i = 0; i < STAGES - 1; i++) begin
            if (r[i] != r[i+1]) edges++;
        end
        return (edges <= 1);
    endfunction

    function automatic ring_t ring_step(input ring_t r);
        return {r[STAGES-2:0], ~r[STAGES-1]};
    endfunction

endpackage

// File: rtl/jring_sync.sv
module jring_sync #(
    parameter int WIDTH = 3,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d_in;
    end

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    assign d_out = stage_q[DEPTH-1];
endmodule

// File: rtl/jring_qualify.sv
module jring_qualify
    import jring_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t now_s,
    output logic advance
);
    ctl_t prev_q;
    logic cnt_rise;
    logic gate_fall;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '{cnt: 1'b0, gate_n: 1'b1, clr: 1'b0};
        else     prev_q <= now_s;
    end

    assign cnt_rise  = now_s.cnt & ~prev_q.cnt & ~now_s.gate_n;
    assign gate_fall = ~now_s.gate_n & prev_q.gate_n & now_s.cnt;
    assign advance   = cnt_rise | gate_fall;

    // R3/R4: a step is only ever requested with the count input high and the gate low
    a_r3_step_levels: assert property (@(posedge clk) disable iff (rst)
        advance |-> (now_s.cnt && !now_s.gate_n));
    // R5: no step while the sampled inputs hold still
    a_r5_quiet_inputs: assert property (@(posedge clk) disable iff (rst)
        (now_s.cnt == prev_q.cnt && now_s.gate_n == prev_q.gate_n) |-> !advance);
endmodule

// File: rtl/jring_state.sv
module jring_state
    import jring_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_s,
    input  logic  advance,
    output ring_t ring_q
);
    ring_t ring_d;

    always_comb begin
        ring_d = ring_q;
        if (clr_s)
            ring_d = '0;
        else if (advance)
            ring_d = ring_legal(ring_q) ? ring_step(ring_q) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) ring_q <= '0;
        else     ring_q <= ring_d;
    end

    // R6: clear seen means count zero on the next cycle
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr_s |=> (ring_q == '0));
    // R9: any step or clear lands on a legal ring pattern
    a_r9_lands_legal: assert property (@(posedge clk) disable iff (rst)
        (advance || clr_s) |=> ring_legal(ring_q));
    // R5: without a step or clear the register holds
    a_r5_hold: assert property (@(posedge clk) disable iff (rst || !ring_legal(ring_q))
        (!advance && !clr_s) |=> $stable(ring_q));
    // R2: a legal step flips exactly one bit (glitch-free decode)
    a_r2_one_bit: assert property (@(posedge clk) disable iff (rst)
        (advance && !clr_s && ring_legal(ring_q)) |=> ($countones(ring_q ^ $past(ring_q)) == 1));
endmodule

// File: rtl/jring_decode.sv
module jring_decode
    import jring_pkg::*;
(
    input  ring_t             ring,
    output logic [COUNTS-1:0] sel,
    output logic              carry
);
    assign sel[0]      = ~ring[STAGES-1] & ~ring[0];
    assign sel[STAGES] =  ring[STAGES-1] &  ring[0];

    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_pair
            assign sel[k]          =  ring[k-1] & ~ring[k];
            assign sel[k + STAGES] = ~ring[k-1] &  ring[k];
        end
    endgenerate

    assign carry = ~ring[STAGES-1];
endmodule

// File: rtl/jring_decade.sv
module jring_decade
    import jring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_in,
    input  logic              gate_n_in,
    input  logic              clr_in,
    output logic [COUNTS-1:0] sel_o,
    output logic              carry_o
);
    ctl_t  raw_ctl;
    ctl_t  sync_ctl;
    logic  advance;
    ring_t ring_q;

    assign raw_ctl = '{cnt: cnt_in, gate_n: ~gate_n_in, clr: clr_in};

    jring_sync #(.WIDTH($bits(ctl_t)), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_ctl),
        .d_out (sync_ctl)
    );

    // The gate travels inverted through the synchronizer so that it resets to "closed".
    ctl_t now_s;
    assign now_s = '{cnt: sync_ctl.cnt, gate_n: ~sync_ctl.gate_n, clr: sync_ctl.clr};

    jring_qualify u_qual (
        .clk     (clk),
        .rst     (rst),
        .now_s   (now_s),
        .advance (advance)
    );

    jring_state u_state (
        .clk     (clk),
        .rst     (rst),
        .clr_s   (now_s.clr),
        .advance (advance),
        .ring_q  (ring_q)
    );

    jring_decode u_dec (
        .ring  (ring_q),
        .sel   (sel_o),
        .carry (carry_o)
    );

    // R2: one select line in every legal state
    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        ring_legal(ring_q) |-> ($countones(sel_o) == 1));
    // R8: carry agrees with the lower half of the selects
    a_r8_carry_half: assert property (@(posedge clk) disable iff (rst)
        ring_legal(ring_q) |-> (carry_o == (|sel_o[STAGES-1:0])));
    // R1: reset leaves count zero
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (sel_o == COUNTS'(1) && carry_o));
endmodule

// File: tb/jring_decade_tb.sv
module jring_decade_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_in = 1'b0;
    logic       gate_n_in = 1'b1;
    logic       clr_in = 1'b0;
    logic [9:0] sel_o;
    logic       carry_o;

    int tests = 0;
    int fails = 0;
    int model = 0;
    bit done  = 0;
    int    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    jring_decade u_dut (
        .clk(clk), .rst(rst), .cnt_in(cnt_in), .gate_n_in(gate_n_in),
        .clr_in(clr_in), .sel_o(sel_o), .carry_o(carry_o)
    );

    task automatic check_now(input int c, input string req);
        logic [9:0] es;
        logic       ec;
        es = 10'(1) << c;
        ec = (c < 5);
        tests++;
        if (sel_o !== es || carry_o !== ec) begin
            fails++;
            $display("FAIL %s: sel=%b carry=%b expected sel=%b carry=%b", req, sel_o, carry_o, es, ec);
        end
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (exp_q.size() > 0) check_now(exp_q.pop_front(), tag_q.pop_front());
    end

    // driver: apply levels, settle, push the expected count
    task automatic drive(input logic c, input logic g, input bit adv, input string req);
        @(negedge clk);
        cnt_in    = c;
        gate_n_in = g;
        repeat (4) @(negedge clk);
        if (adv) model = (model + 1) % 10;
        exp_q.push_back(model);
        tag_q.push_back(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        tests++; fails++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check_now(0, "R1 reset");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_now(0, "R1 after reset");

        drive(0, 0, 0, "R5 gate falls with count low");
        drive(1, 0, 1, "R3 count rises gate low");
        drive(0, 0, 0, "R5 count falls");

        // R3 latency: two edges old value, third edge new value
        @(negedge clk);
        cnt_in = 1'b1;
        repeat (2) @(negedge clk);
        check_now(model, "R3 latency not yet");
        @(negedge clk);
        model = model + 1;
        check_now(model, "R3 latency third edge");

        drive(0, 0, 0, "R5 count falls");
        drive(0, 1, 0, "R5 gate rises");
        drive(1, 1, 0, "R5 count rises gate high");
        drive(1, 0, 1, "R4 gate falls count high");
        drive(1, 1, 0, "R5 gate rises count high");
        drive(1, 0, 1, "R4 gate falls again");

        for (int i = 0; i < 12; i++) begin
            drive(0, 0, 0, "R5 count falls in sweep");
            drive(1, 0, 1, "R7 R8 R2 sweep step");
        end

        drive(0, 1, 0, "R5 park");
        drive(1, 0, 1, "R10 both edges one step");

        @(negedge clk);
        clr_in = 1'b1;
        model  = 0;
        drive(0, 0, 0, "R6 clear");
        drive(1, 0, 0, "R6 count ignored under clear");
        drive(1, 1, 0, "R6 gate ignored under clear");
        drive(1, 0, 0, "R6 gate fall ignored under clear");
        @(negedge clk);
        clr_in = 1'b0;
        drive(0, 0, 0, "R6 clear released");
        drive(1, 0, 1, "R6 counting resumes");
        drive(0, 0, 0, "R5 count falls");

        @(negedge clk);
        force u_dut.u_state.ring_q = 5'b01010;
        @(negedge clk);
        release u_dut.u_state.ring_q;
        model = 9;
        drive(1, 0, 1, "R9 unused pattern recovers to zero");
        drive(0, 0, 0, "R9 holds zero");
        drive(1, 0, 1, "R9 steps after recovery");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule